// File: doc/BRIEF.md
# Modular Exponentiation Sequencer

This block raises a message to a power modulo an odd modulus, returning Z = M^E mod N. All of the arithmetic is done by one shared radix-2 Montgomery multiplier. A state machine feeds it a fixed series of operand pairs.

The series runs in three parts:
- **Entry.** The message is taken into the Montgomery domain and stored as the base. The domain form of one is stored as the accumulator.
- **Loop.** The exponent is scanned from its top bit down to bit 0. For every bit the accumulator is squared. When the bit is set, the accumulator is also multiplied by the base.
- **Exit.** The accumulator is multiplied by one to leave the domain. A single conditional subtraction then puts the result in the range [0, N).

The caller provides K = R^2 mod N, where R = 2^(WIDTH+2). This R matches the WIDTH+2 iterations of the multiplier, so the multiplier needs no final subtraction of its own. A one-cycle start pulse latches the operands. A one-cycle done pulse marks the result.

Top module: `modexp_core`

## Requirements
- R1: After reset, done is 0 and result is 0.
- R2: A start pulse seen while the block is idle latches msgIn, expIn, modIn and rsqIn. When done next pulses, result equals msgIn^expIn mod modIn. This holds for odd modIn of at least 3, msgIn < modIn, and rsqIn = 2^(2*(WIDTH+2)) mod modIn.
- R3: Whenever done is 1, result is less than the latched modulus.
- R4: An exponent of 0 yields result 1.
- R5: A message of 0 with a nonzero exponent yields result 0.
- R6: done is high for exactly one cycle per computation. result changes only in the cycle where done is high, and it holds its value until the next computation completes.
- R7: A start pulse that arrives while a computation is in progress is ignored. The running result is unchanged and no extra done pulse follows.
- R8: All EXPW exponent bits are used, including an all-ones exponent and an exponent whose only set bit is the top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin; only acted on when idle |
| msgIn | input | WIDTH | Message M, below the modulus |
| expIn | input | EXPW | Exponent E |
| modIn | input | WIDTH | Odd modulus N |
| rsqIn | input | WIDTH | Domain constant K = R^2 mod N |
| done | output | 1 | One-cycle pulse: result is valid |
| result | output | WIDTH | M^E mod N |

## Verification
Some internal faults corrupt the accumulator: a wrong operand chosen by the 2:1 selector, a skipped or extra multiply step, or a mis-stepped bit counter. These faults surface only at the end of the computation, as a wrong value on result in the cycle done pulses. This is about (3 + EXPW + popcount(E)) × (WIDTH+4) cycles after start. Exponents with different bit patterns are therefore needed to tell a lost multiply from a lost square. Control faults, such as a sticky done or a restart taken while busy, are visible sooner. They show as a done pulse longer than one cycle, a result that moves outside the done cycle, or a second done pulse.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

  // Operand pair applied to the shared multiplier
  typedef enum logic [2:0] {
    OP_MK = 3'd0,   // message x domain constant
    OP_K1 = 3'd1,   // domain constant x one
    OP_QQ = 3'd2,   // accumulator squared
    OP_QP = 3'd3,   // accumulator x base
    OP_Q1 = 3'd4    // accumulator x one (domain exit)
  } opsel_e;

  typedef struct packed {
    logic   loadIn;
    logic   mulGo;
    opsel_e opSel;
    logic   loadP;
    logic   loadQ;
    logic   loadRes;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PREP = 3'd1,
    ST_PREQ = 3'd2,
    ST_SQR  = 3'd3,
    ST_MUL  = 3'd4,
    ST_POST = 3'd5,
    ST_FIX  = 3'd6,
    ST_FIN  = 3'd7
  } state_e;

endpackage

// File: rtl/mont_mul.sv
module mont_mul #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W:0]   xIn,
  input  logic [W:0]   yIn,
  input  logic [W-1:0] nIn,
  output logic         fin,
  output logic [W:0]   prod
);
  localparam int ITER = W + 2;
  localparam int CW   = $clog2(ITER + 1);
  localparam int AW   = W + 3;

  logic [AW-1:0] acc;
  logic [W+1:0]  xSh;
  logic [W:0]    yR;
  logic [W-1:0]  nR;
  logic [CW-1:0] cnt;
  logic          run;

  logic          xBit, qBit;
  logic [AW-1:0] addY, addN, sum;

  always_comb begin
    xBit = xSh[0];
    qBit = acc[0] ^ (xBit & yR[0]);
    addY = xBit ? AW'(yR) : '0;
    addN = qBit ? AW'(nR) : '0;
    sum  = acc + addY + addN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
      xSh <= '0;
      yR  <= '0;
      nR  <= '0;
      cnt <= '0;
      run <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        acc <= '0;
        xSh <= {1'b0, xIn};
        yR  <= yIn;
        nR  <= nIn;
        cnt <= '0;
        run <= 1'b1;
      end else if (run) begin
        acc <= sum >> 1;
        xSh <= xSh >> 1;
        cnt <= cnt + 1'b1;
        if (cnt == CW'(ITER - 1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assign prod = acc[W:0];

endmodule

// File: rtl/modexp_ctrl.sv
module modexp_ctrl
  import modexp_pkg::*;
#(
  parameter int EW = 16,
  localparam int BW = (EW > 1) ? $clog2(EW) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          mulFin,
  input  logic          expBit,
  output strobe_t       strb,
  output logic [BW-1:0] bitIdx,
  output logic          done
);
  state_e state;
  logic   issued;

  always_comb begin
    strb       = '0;
    strb.opSel = OP_MK;
    unique case (state)
      ST_IDLE: strb.loadIn = start;
      ST_PREP: begin
        strb.opSel = OP_MK;
        strb.mulGo = !issued;
        strb.loadP = issued && mulFin;
      end
      ST_PREQ: begin
        strb.opSel = OP_K1;
        strb.mulGo = !issued;
        strb.loadQ = issued && mulFin;
      end
      ST_SQR: begin
        strb.opSel = OP_QQ;
        strb.mulGo = !issued;
        strb.loadQ = issued && mulFin;
      end
      ST_MUL: begin
        strb.opSel = OP_QP;
        strb.mulGo = !issued;
        strb.loadQ = issued && mulFin;
      end
      ST_POST: begin
        strb.opSel = OP_Q1;
        strb.mulGo = !issued;
        strb.loadQ = issued && mulFin;
      end
      ST_FIX:  strb.loadRes = 1'b1;
      default: ;
    endcase
  end

  assign done = (state == ST_FIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      issued <= 1'b0;
      bitIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state  <= ST_PREP;
          issued <= 1'b0;
          bitIdx <= BW'(EW - 1);
        end
        ST_PREP, ST_PREQ, ST_SQR, ST_MUL, ST_POST: begin
          if (!issued) begin
            issued <= 1'b1;
          end else if (mulFin) begin
            issued <= 1'b0;
            case (state)
              ST_PREP: state <= ST_PREQ;
              ST_PREQ: state <= ST_SQR;
              ST_SQR: begin
                if (expBit)              state <= ST_MUL;
                else if (bitIdx == '0)   state <= ST_POST;
                else begin
                  bitIdx <= bitIdx - 1'b1;
                  state  <= ST_SQR;
                end
              end
              ST_MUL: begin
                if (bitIdx == '0) state <= ST_POST;
                else begin
                  bitIdx <= bitIdx - 1'b1;
                  state  <= ST_SQR;
                end
              end
              default: state <= ST_FIX;
            endcase
          end
        end
        ST_FIX:  state <= ST_FIN;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/modexp_dp.sv
module modexp_dp
  import modexp_pkg::*;
#(
  parameter int W  = 16,
  parameter int EW = 16,
  localparam int BW = (EW > 1) ? $clog2(EW) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [BW-1:0] bitIdx,
  input  logic [W-1:0]  msgIn,
  input  logic [EW-1:0] expIn,
  input  logic [W-1:0]  modIn,
  input  logic [W-1:0]  rsqIn,
  input  logic [W:0]    mulProd,
  output logic [W:0]    opA,
  output logic [W:0]    opB,
  output logic [W-1:0]  modOut,
  output logic          expBit,
  output logic [W-1:0]  result
);
  localparam logic [W:0] ONE = (W+1)'(1);

  logic [W-1:0]  msgR, modR, kR;
  logic [EW-1:0] expR;
  logic [W:0]    pReg, qReg;
  logic [W:0]    loopB;
  logic          qGeN;
  logic [W-1:0]  resNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgR   <= '0;
      expR   <= '0;
      modR   <= '0;
      kR     <= '0;
      pReg   <= '0;
      qReg   <= '0;
      result <= '0;
    end else begin
      if (strb.loadIn) begin
        msgR <= msgIn;
        expR <= expIn;
        modR <= modIn;
        kR   <= rsqIn;
      end
      if (strb.loadP)   pReg   <= mulProd;
      if (strb.loadQ)   qReg   <= mulProd;
      if (strb.loadRes) result <= resNext;
    end
  end

  // 2:1 selector for the loop's second operand
  assign loopB = (strb.opSel == OP_QP) ? pReg : qReg;

  always_comb begin
    unique case (strb.opSel)
      OP_MK:   begin opA = {1'b0, msgR}; opB = {1'b0, kR}; end
      OP_K1:   begin opA = {1'b0, kR};   opB = ONE;        end
      OP_Q1:   begin opA = qReg;         opB = ONE;        end
      default: begin opA = qReg;         opB = loopB;      end
    endcase
  end

  assign qGeN    = (qReg >= {1'b0, modR});
  assign resNext = qGeN ? (qReg[W-1:0] - modR) : qReg[W-1:0];
  assign modOut  = modR;
  assign expBit  = expR[bitIdx];

endmodule

// File: rtl/modexp_core.sv
module modexp_core
  import modexp_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int EXPW  = 16,
  localparam int BW = (EXPW > 1) ? $clog2(EXPW) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] msgIn,
  input  logic [EXPW-1:0]  expIn,
  input  logic [WIDTH-1:0] modIn,
  input  logic [WIDTH-1:0] rsqIn,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  strobe_t          strb;
  logic [BW-1:0]    bitIdx;
  logic             expBit, mulFin, mulGo;
  logic [WIDTH:0]   opA, opB, mulProd;
  logic [WIDTH-1:0] modLat;

  assign mulGo = strb.mulGo;

  modexp_ctrl #(.EW(EXPW)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mulFin(mulFin),
    .expBit(expBit), .strb(strb), .bitIdx(bitIdx), .done(done)
  );

  modexp_dp #(.W(WIDTH), .EW(EXPW)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bitIdx(bitIdx),
    .msgIn(msgIn), .expIn(expIn), .modIn(modIn), .rsqIn(rsqIn),
    .mulProd(mulProd), .opA(opA), .opB(opB), .modOut(modLat),
    .expBit(expBit), .result(result)
  );

  mont_mul #(.W(WIDTH)) i_mul (
    .clk(clk), .rstN(rstN), .go(mulGo), .xIn(opA), .yIn(opB),
    .nIn(modLat), .fin(mulFin), .prod(mulProd)
  );

endmodule

// File: rtl/modexp_chk.sv
module modexp_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         done,
  input logic [W-1:0] result,
  input logic         mulGo,
  input logic         mulFin,
  input logic [W:0]   mulProd,
  input logic [W-1:0] modLat
);
  // R3: presented result is reduced below the modulus
  a_r3_result_range: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result < modLat));

  // R6: done lasts a single cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: result only moves in the done cycle
  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> done);

  // R2: every multiplier output stays below twice the modulus
  a_r2_prod_bound: assert property (@(posedge clk) disable iff (!rstN)
    mulFin |-> (mulProd < {modLat, 1'b0}));

  // R2: each multiplication is launched by a one-cycle strobe
  a_r2_go_single: assert property (@(posedge clk) disable iff (!rstN)
    mulGo |=> !mulGo);

  // R2: no launch while a product is being handed back
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    mulGo |-> !mulFin);

endmodule

bind modexp_core modexp_chk #(.W(WIDTH)) i_chk (
  .clk(clk), .rstN(rstN), .done(done), .result(result),
  .mulGo(mulGo), .mulFin(mulFin), .mulProd(mulProd), .modLat(modLat)
);

// File: tb/test_modexp_core.sv
module test_modexp_core;
  localparam int W  = 16;
  localparam int EW = 16;
  localparam int NV = 8;

  // {message, exponent, modulus}
  localparam logic [47:0] VEC [NV] = '{
    {16'd4,     16'd13,    16'd497},
    {16'd1234,  16'd65535, 16'd65521},
    {16'd2,     16'd10,    16'd1023},
    {16'd65000, 16'd257,   16'd65535},
    {16'd7,     16'd1,     16'd11},
    {16'd3,     16'd32768, 16'd40961},
    {16'd12345, 16'd54321, 16'd60001},
    {16'd2,     16'd2,     16'd3}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  msgIn = '0, modIn = '0, rsqIn = '0;
  logic [EW-1:0] expIn = '0;
  logic          done;
  logic [W-1:0]  result;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;

  always #4 clk = ~clk;

  modexp_core #(.WIDTH(W), .EXPW(EW)) i_modexp_core (
    .clk(clk), .rstN(rstN), .start(start), .msgIn(msgIn), .expIn(expIn),
    .modIn(modIn), .rsqIn(rsqIn), .done(done), .result(result)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic longint kConst(input longint n);
    longint r = 1 % n;
    for (int i = 0; i < 2 * (W + 2); i++) r = (r * 2) % n;
    return r;
  endfunction

  function automatic longint refPow(input longint m, input longint e, input longint n);
    longint r = 1 % n;
    for (int i = EW - 1; i >= 0; i--) begin
      r = (r * r) % n;
      if (e[i]) r = (r * (m % n)) % n;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic launch(input longint m, input longint e, input longint n);
    @(posedge clk); #1;
    msgIn = W'(m); expIn = EW'(e); modIn = W'(n); rsqIn = W'(kConst(n));
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic waitDone(output logic [W-1:0] res, output bit got);
    got = 0;
    res = '0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin got = 1; res = result; break; end
      @(posedge clk); #1;
    end
  endtask

  task automatic runOne(input string tag, input longint m, input longint e,
                        input longint n);
    logic [W-1:0] res;
    bit got;
    launch(m, e, n);
    waitDone(res, got);
    chk({tag, " done seen"}, got, 1);
    chk(tag, res, refPow(m, e, n));
    @(posedge clk); #1;
    chk("R6 done single cycle", done, 0);
  endtask

  initial begin
    logic [W-1:0] res, held;
    bit got;
    int extra;

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 done at reset", done, 0);
    chk("R1 result at reset", result, 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1 done after release", done, 0);

    // R2 / R3: vector table
    for (int v = 0; v < NV; v++) begin
      runOne("R2 R3 vector", VEC[v][47:32], VEC[v][31:16], VEC[v][15:0]);
    end

    // R4: zero exponent
    runOne("R4 zero exponent", 1234, 0, 65521);
    runOne("R4 zero exponent small", 5, 0, 7);

    // R5: zero message
    runOne("R5 zero message", 0, 777, 40961);

    // R8: all-ones and top-bit-only exponents
    runOne("R8 all ones exponent", 3, 16'hFFFF, 497);
    runOne("R8 top bit exponent", 5, 16'h8000, 1023);
    runOne("R8 unit message", 1, 16'hA5A5, 65535);

    // R6: result holds after done
    runOne("R6 setup", 9, 300, 60001);
    held = result;
    repeat (40) @(posedge clk);
    #1;
    chk("R6 result held", result, held);

    // R7: start while busy is ignored
    launch(11, 54321, 65521);
    repeat (60) @(posedge clk);
    #1;
    msgIn = 16'd3; expIn = 16'd2; modIn = 16'd7; rsqIn = W'(kConst(7));
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    waitDone(res, got);
    chk("R7 done seen", got, 1);
    chk("R7 busy start ignored", res, refPow(11, 54321, 65521));
    extra = 0;
    for (int i = 0; i < 1200; i++) begin
      @(posedge clk); #1;
      if (done) extra++;
    end
    chk("R7 no extra done", extra, 0);
    chk("R7 result unchanged", result, refPow(11, 54321, 65521));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule